// File: doc/BRIEF.md
# Flash Write Status Reporter

This block forms the word a flash device puts on its data pins when the host reads it while an internal program or erase is running or while an erase is suspended. It takes the busy and suspend state from the device's sequencer. It also takes the kind of operation, the data word being programmed, a flag that says whether the current read address lies in the suspended sector, a timeout flag and an erase-started flag. From these it builds a polling word. A host can tell from that word whether the write has finished, whether it has failed by timeout, and which sector is suspended. When no status applies, array data passes through unchanged.

Two toggle flip-flops advance each time a qualified read ends. A qualified read is one with chip enable and output enable both low. The end of a read is seen on the system clock, so a polling read always sees a stable value and the next read sees the other value. A registered ready level goes low one clock after the sequencer or an internal reset becomes busy.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `ready` is 1, both toggle bits are 0, and when idle `rd_data` equals `array_data`.
- R2: While `op_busy` is high and `op_erase` is low, `rd_data[7]` is the inverse of `prog_data[7]` and `rd_data[3]` is 0.
- R3: While `op_busy` is high, bit 6 of `rd_data` holds steady during a read and inverts one clock after each read strobe ends, where a read strobe is `ce_n` and `oe_n` both low.
- R4: While `op_busy` and `op_erase` are both high, `rd_data[7]` is 0 and `rd_data[3]` equals `erase_begun`.
- R5: While `op_busy` is high, `rd_data[5]` equals `time_limit`.
- R6: `ready` is 0 in the clock after any clock in which `op_busy` or `reset_busy` is high, and 1 in the clock after both are low.
- R7: With `op_busy` low, `erase_susp` high and `addr_in_susp` high, `rd_data[7]` is 1, bit 6 does not change across reads, and bit 2 inverts one clock after each read ends.
- R8: With `op_busy` low and either `erase_susp` or `addr_in_susp` low, `rd_data` equals `array_data`, and reads there leave bit 2 unchanged, as a later read in the suspended sector shows.
- R9: Bit 2 does not invert on reads while `op_busy` is high.
- R10: A read strobe that ends in the same clock in which `op_busy` falls does not advance the bit 6 toggle.
- R11: In every status mode, bits 4, 1 and 0, and all bits above 7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_busy | input | 1 | Internal program or erase is running |
| op_erase | input | 1 | Running operation is an erase (0 means program) |
| erase_susp | input | 1 | An erase is suspended |
| addr_in_susp | input | 1 | Current read address lies in the suspended sector |
| time_limit | input | 1 | Operation has exceeded its time limit |
| erase_begun | input | 1 | Erase window has closed and erasing has started |
| reset_busy | input | 1 | Internal reset triggered during an operation is still running |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_data | input | DW | Data word being programmed |
| array_data | input | DW | Array contents at the read address |
| rd_data | output | DW | Word returned to the host |
| ready | output | 1 | Ready level, 1 when ready and 0 when busy |

## Verification
The end of a read and the completion of an operation can land on the same clock edge. When they do, the toggle must not advance, because the operation is no longer busy at that edge. The bench provokes this by releasing the read strobe and dropping `op_busy` in the same cycle. It then restarts an operation and confirms that bit 6 reads the value it had before that last read. It also confirms that `ready` rises one clock later.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_busy,
  input  logic          op_erase,
  input  logic          erase_susp,
  input  logic          addr_in_susp,
  input  logic          time_limit,
  input  logic          erase_begun,
  input  logic          reset_busy,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          ready
);

  logic rd_strobe, strb_q, rd_end;
  logic tog6, tog2;
  logic susp_hit;

  assign rd_strobe = ~ce_n & ~oe_n;
  assign rd_end    = strb_q & ~rd_strobe;
  assign susp_hit  = ~op_busy & erase_susp & addr_in_susp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      tog6   <= 1'b0;
      tog2   <= 1'b0;
      ready  <= 1'b1;
    end else begin
      strb_q <= rd_strobe;
      ready  <= ~(op_busy | reset_busy);
      if (rd_end && op_busy)  tog6 <= ~tog6;
      if (rd_end && susp_hit) tog2 <= ~tog2;
    end
  end

  always_comb begin
    rd_data = array_data;
    if (op_busy) begin
      rd_data    = '0;
      rd_data[7] = op_erase ? 1'b0 : ~prog_data[7];
      rd_data[6] = tog6;
      rd_data[5] = time_limit;
      rd_data[3] = op_erase & erase_begun;
      rd_data[2] = tog2;
    end else if (susp_hit) begin
      rd_data    = '0;
      rd_data[7] = 1'b1;
      rd_data[6] = tog6;
      rd_data[2] = tog2;
    end
  end

  assert_busy_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy || reset_busy) |=> !ready);
  assert_idle_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy && !reset_busy) |=> ready);
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && op_busy) |=> (tog6 != $past(tog6)));
  assert_freeze_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_busy |=> $stable(tog6));
  assert_dq2_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |=> $stable(tog2));
  assert_dq2_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_susp || !addr_in_susp) |=> $stable(tog2));
  assert_stable_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && strb_q) |=> $stable(tog6));

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_busy = 0, op_erase = 0, erase_susp = 0, addr_in_susp = 0;
  logic time_limit = 0, erase_begun = 0, reset_busy = 0;
  logic ce_n = 1, oe_n = 1;
  logic [7:0] prog_data = 8'h00, array_data = 8'h5C;
  logic [7:0] rd_data;
  logic ready;
  int checks = 0, errors = 0;
  logic e6 = 1'b0, e2 = 1'b0;
  logic [7:0] got;

  always #2 clk = ~clk;

  flash_status_gen #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .erase_susp(erase_susp), .addr_in_susp(addr_in_susp), .time_limit(time_limit),
    .erase_begun(erase_begun), .reset_busy(reset_busy), .ce_n(ce_n), .oe_n(oe_n),
    .prog_data(prog_data), .array_data(array_data), .rd_data(rd_data), .ready(ready));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_read(output logic [7:0] v);
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); v = rd_data;
    @(negedge clk); if (rd_data !== v) chk("R3 stable in read", rd_data, v);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready", {7'b0, ready}, 8'h01);
    chk("R1 idle data", rd_data, array_data);
  endtask

  task automatic t_program;
    op_busy = 1; op_erase = 0; prog_data = 8'hA5;
    @(negedge clk);
    chk("R6 ready low", {7'b0, ready}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      host_read(got);
      chk("R2 dq7", {7'b0, got[7]}, 8'h00);
      chk("R3 dq6", {7'b0, got[6]}, {7'b0, e6});
      chk("R2 dq3", {7'b0, got[3]}, 8'h00);
      chk("R11 spare bits", got & 8'h13, 8'h00);
      chk("R9 dq2", {7'b0, got[2]}, {7'b0, e2});
      e6 = ~e6;
    end
    prog_data = 8'h35; time_limit = 1;
    host_read(got);
    chk("R2 dq7 inv", {7'b0, got[7]}, 8'h01);
    chk("R5 dq5", {7'b0, got[5]}, 8'h01);
    e6 = ~e6;
    time_limit = 0;
  endtask

  task automatic t_erase;
    op_erase = 1; erase_begun = 0;
    host_read(got);
    chk("R4 dq7", {7'b0, got[7]}, 8'h00);
    chk("R4 dq3 before", {7'b0, got[3]}, 8'h00);
    chk("R5 dq5 low", {7'b0, got[5]}, 8'h00);
    e6 = ~e6;
    erase_begun = 1;
    host_read(got);
    chk("R4 dq3 after", {7'b0, got[3]}, 8'h01);
    chk("R3 dq6 erase", {7'b0, got[6]}, {7'b0, e6});
    e6 = ~e6;
    erase_begun = 0;
  endtask

  task automatic t_suspend;
    op_busy = 0; erase_susp = 1; addr_in_susp = 1;
    @(negedge clk);
    chk("R6 ready high", {7'b0, ready}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      host_read(got);
      chk("R7 dq7", {7'b0, got[7]}, 8'h01);
      chk("R7 dq6 frozen", {7'b0, got[6]}, {7'b0, e6});
      chk("R7 dq2", {7'b0, got[2]}, {7'b0, e2});
      chk("R11 susp spare", got & 8'h3B, 8'h00);
      e2 = ~e2;
    end
    addr_in_susp = 0; array_data = 8'hC3;
    host_read(got);
    chk("R8 outside data", got, 8'hC3);
    host_read(got);
    addr_in_susp = 1;
    host_read(got);
    chk("R8 dq2 unchanged", {7'b0, got[2]}, {7'b0, e2});
    e2 = ~e2;
    erase_susp = 0; addr_in_susp = 0;
    @(negedge clk);
    chk("R8 idle data", rd_data, 8'hC3);
  endtask

  task automatic t_reset_busy;
    reset_busy = 1;
    @(negedge clk);
    chk("R6 reset busy", {7'b0, ready}, 8'h00);
    reset_busy = 0;
    @(negedge clk);
    chk("R6 reset done", {7'b0, ready}, 8'h01);
  endtask

  task automatic t_same_cycle;
    op_busy = 1; op_erase = 0; prog_data = 8'h00;
    @(negedge clk); ce_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk);
    ce_n = 1; oe_n = 1; op_busy = 0;
    @(negedge clk);
    chk("R10 ready", {7'b0, ready}, 8'h01);
    op_busy = 1;
    @(negedge clk);
    chk("R10 dq6 held", {7'b0, rd_data[6]}, {7'b0, e6});
    op_busy = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_reset_busy();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule